// File: doc/BRIEF.md
# Scan-cycle RAM write controller

This block decides when the channel address RAM of a port scanner may be written. The scanner produces a strobe once per scan, two clocks after each end of scan. The write window is aligned to these strobes: once armed, the window opens at one strobe and closes at the next. It therefore covers exactly one whole scan. During the window the block drives a write enable to the RAM. In the same cycles it drives a select that steers the write port address onto the RAM address lines.

The window is armed in two ways. An error indication from the diagnostic logic arms it, and so does reset, which forces one initialising write after power-on. An error seen between strobes is held until the next strobe. Errors that occur while a window is already open are discarded, so a window never runs longer than one scan.

A second output, the inhibit, is active for one whole scan on alternate scans. It is driven by a phase counter that advances on every strobe and is cleared by reset.

Top module: `scan_wr_ctrl`

## Requirements
- R1: While rst_ni is low, and in the cycle after it is released, wr_en_o, addr_sel_o and inhibit_o are all 0.
- R2: Without any error, the first scan_end_i strobe after reset opens a write window: wr_en_o is 1 in the cycle after that strobe.
- R3: An err_i pulse while no window is open, and not on a strobe cycle, is held: wr_en_o stays 0 until the next strobe and becomes 1 in the cycle after it.
- R4: An open window closes at the next strobe: wr_en_o is 0 in the cycle after the strobe that follows the opening one.
- R5: addr_sel_o equals wr_en_o in every cycle.
- R6: err_i pulses while a window is open, including one in the cycle of the closing strobe, are discarded: no further window opens at later strobes.
- R7: inhibit_o is 0 after reset and inverts in the cycle after every strobe (default INHIBIT_PERIOD = 2), so it is 1 during every other scan, starting with the scan after the first strobe.
- R8: An err_i pulse in the same cycle as a strobe, while no window is open, opens a window at that strobe.
- R9: wr_en_o and inhibit_o change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Error indication that arms a write window |
| scan_end_i | input | 1 | One-cycle strobe, second-delayed end of scan |
| wr_en_o | output | 1 | RAM write enable |
| addr_sel_o | output | 1 | Selects the write port address onto the RAM address |
| inhibit_o | output | 1 | Inhibit, active for one whole scan on alternate scans |

## Verification
Arming and the window boundary can fall in the same cycle: an error can arrive on the very strobe that opens or closes a window. The vector table drives err_i together with scan_end_i in both situations. When the window is idle, the window is expected to open at once (R8). When the window is open, it is expected to close and stay closed at the following strobe (R6). Each case also checks the inhibit toggle taken at the same strobe.

// File: rtl/scan_wr_pkg.sv
package scan_wr_pkg;

  typedef struct packed {
    logic wr_en;
    logic addr_sel;
  } wr_ctl_t;

  function automatic int phase_w(input int period);
    return (period <= 2) ? 1 : $clog2(period);
  endfunction

endpackage

// File: rtl/scan_arm.sv
module scan_arm #(
  parameter bit INIT_WRITE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic strobe_i,
  input  logic win_open_i,
  output logic launch_o
);

  logic arm_q;

  // arm held between strobes; consumed by the next strobe while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       arm_q <= INIT_WRITE;
    else if (strobe_i && !win_open_i)  arm_q <= 1'b0;
    else if (err_i && !win_open_i)     arm_q <= 1'b1;
  end

  assign launch_o = strobe_i && !win_open_i && (arm_q || err_i);

endmodule

// File: rtl/scan_win.sv
module scan_win
  import scan_wr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    strobe_i,
  input  logic    launch_i,
  output logic    open_o,
  output wr_ctl_t ctl_o
);

  logic open_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (strobe_i) open_q <= !open_q && launch_i;
  end

  // separate flop keeps select and enable on matched, short paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= 1'b0;
    else if (strobe_i) sel_q <= !sel_q && launch_i;
  end

  assign open_o         = open_q;
  assign ctl_o.wr_en    = open_q;
  assign ctl_o.addr_sel = sel_q;

endmodule

// File: rtl/scan_phase.sv
module scan_phase
  import scan_wr_pkg::*;
#(
  parameter int INHIBIT_PERIOD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic inhibit_o
);

  localparam int PW = phase_w(INHIBIT_PERIOD);
  localparam logic [PW-1:0] LAST = PW'(INHIBIT_PERIOD - 1);

  generate
    if (INHIBIT_PERIOD == 2) begin : g_toggle
      logic ph_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       ph_q <= 1'b0;
        else if (strobe_i) ph_q <= !ph_q;
      end
      assign inhibit_o = ph_q;
    end else begin : g_count
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (strobe_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      assign inhibit_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/scan_wr_ctrl.sv
module scan_wr_ctrl
  import scan_wr_pkg::*;
#(
  parameter bit INIT_WRITE     = 1'b1,
  parameter int INHIBIT_PERIOD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic scan_end_i,
  output logic wr_en_o,
  output logic addr_sel_o,
  output logic inhibit_o
);

  logic    launch, win_open;
  wr_ctl_t ctl;

  scan_arm #(.INIT_WRITE(INIT_WRITE)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_i      (err_i),
    .strobe_i   (scan_end_i),
    .win_open_i (win_open),
    .launch_o   (launch)
  );

  scan_win u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (scan_end_i),
    .launch_i (launch),
    .open_o   (win_open),
    .ctl_o    (ctl)
  );

  scan_phase #(.INHIBIT_PERIOD(INHIBIT_PERIOD)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (scan_end_i),
    .inhibit_o (inhibit_o)
  );

  assign wr_en_o    = ctl.wr_en;
  assign addr_sel_o = ctl.addr_sel;

endmodule

// File: rtl/scan_wr_ctrl_chk.sv
module scan_wr_ctrl_chk #(
  parameter int INHIBIT_PERIOD = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic err_i,
  input logic scan_end_i,
  input logic wr_en_o,
  input logic addr_sel_o,
  input logic inhibit_o
);

  // R5
  sel_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_sel_o == wr_en_o);

  // R4
  win_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(scan_end_i) && $past(wr_en_o) |-> !wr_en_o);

  // R8
  err_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(scan_end_i) && $past(err_i) && !$past(wr_en_o) |-> wr_en_o);

  // R9
  wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(scan_end_i) |-> $stable(wr_en_o));

  // R9
  inh_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(scan_end_i) |-> $stable(inhibit_o));

  generate
    if (INHIBIT_PERIOD == 2) begin : g_tog
      // R7
      inh_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(scan_end_i) |-> inhibit_o != $past(inhibit_o));
    end
  endgenerate

endmodule

bind scan_wr_ctrl scan_wr_ctrl_chk #(.INHIBIT_PERIOD(INHIBIT_PERIOD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_i      (err_i),
  .scan_end_i (scan_end_i),
  .wr_en_o    (wr_en_o),
  .addr_sel_o (addr_sel_o),
  .inhibit_o  (inhibit_o)
);

// File: tb/tb_scan_wr_ctrl.sv
`timescale 1ns/1ps
module tb_scan_wr_ctrl;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic err = 1'b0;
  logic se = 1'b0;
  logic wr_en, addr_sel, inhibit;
  int   n_chk = 0;
  int   n_err = 0;

  always #2.5 clk = ~clk;

  scan_wr_ctrl dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .err_i      (err),
    .scan_end_i (se),
    .wr_en_o    (wr_en),
    .addr_sel_o (addr_sel),
    .inhibit_o  (inhibit)
  );

  // {err, strobe, exp_wr, exp_inh}, checked after the edge that samples them
  localparam int NV = 16;
  localparam logic [3:0] VEC [NV] = '{
    4'b0000,  // R1 idle after reset
    4'b0111,  // R2 power-on window opens
    4'b0011,
    4'b1011,  // R6 error inside window
    4'b0100,  // R4 close
    4'b0000,
    4'b0101,  // R6 no window follows
    4'b1001,  // R3 latched
    4'b0001,
    4'b0110,  // R3 opens at strobe
    4'b0101,  // R4 one-cycle scan
    4'b1110,  // R8 error on strobe while idle
    4'b0010,
    4'b1101,  // R6 error on closing strobe
    4'b0100,  // R6 confirm dropped
    4'b0000
  };

  function automatic string vtag(input int i);
    case (i)
      0:        return "R1";
      1, 2:     return "R2";
      4, 10:    return "R4";
      7, 8, 9:  return "R3";
      11, 12:   return "R8";
      default:  return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic s);
    @(negedge clk);
    err = e;
    se  = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    chk("R1", "wr_en in reset", wr_en, 1'b0);
    chk("R1", "inhibit in reset", inhibit, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2]);
      chk(vtag(i), "wr_en", wr_en, VEC[i][1]);
      chk("R5", "addr_sel", addr_sel, VEC[i][1]);
      chk(i == 0 ? "R1" : "R7", "inhibit", inhibit, VEC[i][0]);
    end

    // R3 held error, no immediate effect
    step(1'b1, 1'b0);
    chk("R3", "wr_en before strobe", wr_en, 1'b0);
    step(1'b0, 1'b1);
    chk("R3", "wr_en after strobe", wr_en, 1'b1);
    chk("R7", "inhibit after strobe", inhibit, 1'b1);

    // R1 reset while window open
    @(negedge clk);
    se = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1", "wr_en mid-window reset", wr_en, 1'b0);
    chk("R1", "addr_sel mid-window reset", addr_sel, 1'b0);
    chk("R1", "inhibit mid-window reset", inhibit, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b0, 1'b0);
    chk("R1", "wr_en after release", wr_en, 1'b0);
    chk("R9", "inhibit no strobe", inhibit, 1'b0);
    step(1'b0, 1'b1);
    chk("R2", "wr_en re-init write", wr_en, 1'b1);
    chk("R7", "inhibit first scan", inhibit, 1'b1);
    step(1'b0, 1'b0);
    chk("R9", "wr_en held mid-scan", wr_en, 1'b1);
    step(1'b0, 1'b1);
    chk("R4", "wr_en closed", wr_en, 1'b0);
    chk("R7", "inhibit second scan", inhibit, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule